// File: doc/BRIEF.md
# Legacy I/O Configuration Register Decoder

This block is the configuration register file of a legacy peripheral controller. A host reaches it through two byte-wide ports on a simple bus. The host first writes a register index to the index port. It then reads or writes the data port, which acts on the register that index selects. The registers are a device-identification byte, a function-select byte and four base-address bytes. The base-address bytes serve one parallel port, two serial ports and one floppy controller.

From the stored values the block drives an enable and a 10-bit I/O base for each peripheral. It also compares every incoming 10-bit I/O address with the window of each enabled device. When the address falls in a window, it raises that device's select line. The peripherals themselves and any DMA or interrupt routing are outside this block.

Top module: `legacy_io_cfg`

## Requirements
- R1: Synchronous reset sets the index to 0x00. It loads the function-select register (index 0xE2) with 0x0F. It loads the floppy base (0xE3) with 0xFC, giving I/O base 0x3F0, and the parallel base (0xE6) with 0xDE, giving 0x378. It loads serial 0 base (0xE7) with 0xFE, giving 0x3F8, and serial 1 base (0xE8) with 0xBE, giving 0x2F8. The identification register (0xE0) reads 0x3C.
- R2: A write with `host_port`=0 loads the index. The index is held until it is rewritten, and it reads back on the index port.
- R3: A data write to index 0xE2 stores only bits [4:0] of the written byte. Bits [7:5] read as zero.
- R4: The parallel port is enabled unless function-select bits [1:0] equal 2'b11.
- R5: Function-select bit 2 enables serial 0, bit 3 enables serial 1 and bit 4 enables the floppy controller.
- R6: A data write to 0xE3 stores the byte ANDed with 0xFC. The floppy base equals the stored byte shifted left by two.
- R7: A data write to 0xE6 stores the byte unchanged. The parallel base equals the stored byte shifted left by two.
- R8: Data writes to 0xE7 and 0xE8 store the byte ANDed with 0xFE. The serial bases equal the stored bytes shifted left by two.
- R9: Data writes to 0xE0 and to 0xFD through 0xFF change no register. 0xE0 always reads 0x3C.
- R10: Every index other than 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 reads 0x00. A data write to such an index changes nothing.
- R11: A select line is high only while its device is enabled and `io_addr` lies in [base, base+span). The span is 4 bytes for the parallel port and 8 bytes for each serial port and for the floppy controller.
- R12: Registers change only on a rising clock edge while `host_wr` is high. With `host_wr` low, the value on `host_wdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte of the selected port (combinational) |
| io_addr | input | 10 | I/O address to decode |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | 2 | Serial port enables, bit i for serial i |
| fdc_en | output | 1 | Floppy controller enable |
| par_base | output | 10 | Parallel port I/O base |
| ser0_base | output | 10 | Serial 0 I/O base |
| ser1_base | output | 10 | Serial 1 I/O base |
| fdc_base | output | 10 | Floppy controller I/O base |
| par_sel | output | 1 | Parallel window hit |
| ser_sel | output | 2 | Serial window hits |
| fdc_sel | output | 1 | Floppy window hit |

## Verification
A wrong stored register shows on the enables, the bases and the data-port read in the cycle after the faulty write edge. It shows at once, because the outputs decode the registers without further staging. A wrong mask shows as extra set bits on readback and as a base that is off by a multiple of four. A bad window compare shows as a select that rises one address early or late at a window edge. The bench probes those edges directly. A lost or corrupted index shows as the wrong register answering, which the read of the index port exposes on the same cycle.

// File: rtl/legacy_io_cfg_pkg.sv
package legacy_io_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int IO_AW  = 10;
  localparam int SER_N  = 2;

  localparam logic [7:0] IX_ID   = 8'hE0;
  localparam logic [7:0] IX_FSEL = 8'hE2;
  localparam logic [7:0] IX_FDC  = 8'hE3;
  localparam logic [7:0] IX_PAR  = 8'hE6;
  localparam logic [7:0] IX_SER0 = 8'hE7;
  localparam logic [7:0] IX_SER1 = 8'hE8;
  localparam logic [7:0] IX_RO_LO = 8'hFD;

  localparam logic [7:0] MSK_FSEL = 8'h1F;
  localparam logic [7:0] MSK_FDC  = 8'hFC;
  localparam logic [7:0] MSK_PAR  = 8'hFF;
  localparam logic [7:0] MSK_SER  = 8'hFE;

  localparam int PAR_SPAN_LG = 2;
  localparam int SER_SPAN_LG = 3;
  localparam int FDC_SPAN_LG = 3;

  typedef struct packed {
    logic [4:0] fsel;
    logic [7:0] fdc;
    logic [7:0] par;
    logic [7:0] ser0;
    logic [7:0] ser1;
  } cfg_regs_t;

  function automatic logic [IO_AW-1:0] reg_to_base(input logic [7:0] v);
    return {v, 2'b00};
  endfunction

  function automatic logic [7:0] mask_of(input logic [7:0] idx);
    case (idx)
      IX_FSEL:          return MSK_FSEL;
      IX_FDC:           return MSK_FDC;
      IX_PAR:           return MSK_PAR;
      IX_SER0, IX_SER1: return MSK_SER;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic is_read_only(input logic [7:0] idx);
    return (idx == IX_ID) || (idx >= IX_RO_LO);
  endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import legacy_io_cfg_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h3C,
  parameter logic [7:0] RST_FSEL = 8'h0F,
  parameter logic [7:0] RST_FDC  = 8'hFC,
  parameter logic [7:0] RST_PAR  = 8'hDE,
  parameter logic [7:0] RST_SER0 = 8'hFE,
  parameter logic [7:0] RST_SER1 = 8'hBE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_port,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output cfg_regs_t   regs
);
  logic [7:0] index_q;
  cfg_regs_t  regs_q;
  logic [7:0] wmasked;
  logic [7:0] data_rd;

  // named events for assertions
  logic wr_idx_evt, wr_data_evt, wr_ro_evt;
  assign wr_idx_evt  = host_wr && !host_port;
  assign wr_data_evt = host_wr && host_port;
  assign wr_ro_evt   = wr_data_evt && is_read_only(index_q);

  assign wmasked = host_wdata & mask_of(index_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q     <= 8'h00;
      regs_q.fsel <= RST_FSEL[4:0] & MSK_FSEL[4:0];
      regs_q.fdc  <= RST_FDC & MSK_FDC;
      regs_q.par  <= RST_PAR & MSK_PAR;
      regs_q.ser0 <= RST_SER0 & MSK_SER;
      regs_q.ser1 <= RST_SER1 & MSK_SER;
    end else begin
      if (wr_idx_evt) index_q <= host_wdata;
      if (wr_data_evt) begin
        case (index_q)
          IX_FSEL: regs_q.fsel <= wmasked[4:0];
          IX_FDC:  regs_q.fdc  <= wmasked;
          IX_PAR:  regs_q.par  <= wmasked;
          IX_SER0: regs_q.ser0 <= wmasked;
          IX_SER1: regs_q.ser1 <= wmasked;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (index_q)
      IX_ID:   data_rd = ID_VALUE;
      IX_FSEL: data_rd = {3'b000, regs_q.fsel};
      IX_FDC:  data_rd = regs_q.fdc;
      IX_PAR:  data_rd = regs_q.par;
      IX_SER0: data_rd = regs_q.ser0;
      IX_SER1: data_rd = regs_q.ser1;
      default: data_rd = 8'h00;
    endcase
  end

  assign host_rdata = host_port ? data_rd : index_q;
  assign regs = regs_q;

  // R2
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_idx_evt)) |-> $stable(index_q));

  // R12
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_data_evt)) |-> $stable(regs_q));

  // R9
  ro_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_ro_evt)) |-> $stable(regs_q));

  // R8
  ser_lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !regs_q.ser0[0] && !regs_q.ser1[0]);

  // R6
  fdc_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    regs_q.fdc[1:0] == 2'b00);
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
  import legacy_io_cfg_pkg::*;
(
  input  logic [4:0]       fsel,
  output logic             par_en,
  output logic [SER_N-1:0] ser_en,
  output logic             fdc_en
);
  // parallel port is off only for the code 2'b11
  assign par_en = (fsel[1:0] != 2'b11);

  for (genvar i = 0; i < SER_N; i++) begin : g_ser
    assign ser_en[i] = fsel[2+i];
  end

  assign fdc_en = fsel[2+SER_N];
endmodule

// File: rtl/io_window.sv
module io_window #(
  parameter int AW      = 10,
  parameter int SPAN_LG = 3
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int SPAN = 1 << SPAN_LG;

  logic          tag_eq;
  logic [AW:0]   lim;

  assign tag_eq = (addr[AW-1:SPAN_LG] == base[AW-1:SPAN_LG]);
  assign hit    = en && tag_eq;
  assign lim    = {1'b0, base} + (AW+1)'(SPAN);

  // R11
  always_comb begin
    if (hit) begin
      win_range_chk: assert ({1'b0, addr} >= {1'b0, base} && {1'b0, addr} < lim);
    end
  end
endmodule

// File: rtl/legacy_io_cfg.sv
module legacy_io_cfg
  import legacy_io_cfg_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h3C,
  parameter logic [7:0] RST_FSEL = 8'h0F,
  parameter logic [7:0] RST_FDC  = 8'hFC,
  parameter logic [7:0] RST_PAR  = 8'hDE,
  parameter logic [7:0] RST_SER0 = 8'hFE,
  parameter logic [7:0] RST_SER1 = 8'hBE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_port,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic [9:0]  io_addr,
  output logic        par_en,
  output logic [1:0]  ser_en,
  output logic        fdc_en,
  output logic [9:0]  par_base,
  output logic [9:0]  ser0_base,
  output logic [9:0]  ser1_base,
  output logic [9:0]  fdc_base,
  output logic        par_sel,
  output logic [1:0]  ser_sel,
  output logic        fdc_sel
);
  cfg_regs_t regs;
  logic [IO_AW-1:0] ser_base [SER_N];

  cfg_regfile #(
    .ID_VALUE(ID_VALUE), .RST_FSEL(RST_FSEL), .RST_FDC(RST_FDC),
    .RST_PAR(RST_PAR), .RST_SER0(RST_SER0), .RST_SER1(RST_SER1)
  ) regs_i (
    .clk(clk), .rst(rst), .host_port(host_port), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .regs(regs)
  );

  fsel_decode fsel_i (
    .fsel(regs.fsel), .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en)
  );

  assign par_base    = reg_to_base(regs.par);
  assign fdc_base    = reg_to_base(regs.fdc);
  assign ser_base[0] = reg_to_base(regs.ser0);
  assign ser_base[1] = reg_to_base(regs.ser1);
  assign ser0_base   = ser_base[0];
  assign ser1_base   = ser_base[1];

  io_window #(.AW(IO_AW), .SPAN_LG(PAR_SPAN_LG)) par_win_i (
    .en(par_en), .base(par_base), .addr(io_addr), .hit(par_sel)
  );
  io_window #(.AW(IO_AW), .SPAN_LG(FDC_SPAN_LG)) fdc_win_i (
    .en(fdc_en), .base(fdc_base), .addr(io_addr), .hit(fdc_sel)
  );
  for (genvar i = 0; i < SER_N; i++) begin : g_ser_win
    io_window #(.AW(IO_AW), .SPAN_LG(SER_SPAN_LG)) ser_win_i (
      .en(ser_en[i]), .base(ser_base[i]), .addr(io_addr), .hit(ser_sel[i])
    );
  end

  // R11
  sel_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_sel || par_en) && (!fdc_sel || fdc_en) && ((ser_sel & ~ser_en) == 2'b00));

  // R4
  par_code3_chk: assert property (@(posedge clk) disable iff (rst)
    (regs.fsel[1:0] == 2'b11) |-> !par_en);
endmodule

// File: tb/legacy_io_cfg_tb_top.sv
module legacy_io_cfg_tb_top;
  logic       clk = 0;
  logic       rst;
  logic       host_port, host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic [9:0] io_addr;
  logic       par_en, fdc_en, par_sel, fdc_sel;
  logic [1:0] ser_en, ser_sel;
  logic [9:0] par_base, ser0_base, ser1_base, fdc_base;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  legacy_io_cfg dut_i (
    .clk(clk), .rst(rst), .host_port(host_port), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .io_addr(io_addr),
    .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en),
    .par_base(par_base), .ser0_base(ser0_base), .ser1_base(ser1_base),
    .fdc_base(fdc_base), .par_sel(par_sel), .ser_sel(ser_sel), .fdc_sel(fdc_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic port, input logic [7:0] d);
    @(negedge clk);
    host_port = port; host_wr = 1; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic peek(input logic [7:0] idx, output logic [7:0] v);
    put(0, idx);
    host_port = 1; #1;
    v = host_rdata;
  endtask

  task automatic poke(input logic [7:0] idx, input logic [7:0] d);
    put(0, idx);
    put(1, d);
  endtask

  function automatic logic [9:0] exp_base(input logic [7:0] v);
    return 10'(v) * 10'd4;
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    host_port = 0; #1;
    chk("R1 index", host_rdata, 8'h00);
    peek(8'hE0, v); chk("R1 id", v, 8'h3C);
    peek(8'hE2, v); chk("R1 fsel", v, 8'h0F);
    chk("R1 fdc base", fdc_base, 10'h3F0);
    chk("R1 par base", par_base, 10'h378);
    chk("R1 ser0 base", ser0_base, 10'h3F8);
    chk("R1 ser1 base", ser1_base, 10'h2F8);
    chk("R1 enables", {par_en, ser_en, fdc_en}, 4'b0110);
  endtask

  task automatic t_index();
    put(0, 8'h5A);
    @(negedge clk); @(negedge clk);
    host_port = 0; #1;
    chk("R2 index hold", host_rdata, 8'h5A);
  endtask

  task automatic t_fsel();
    logic [7:0] v;
    poke(8'hE2, 8'hFF); peek(8'hE2, v);
    chk("R3 mask", v, 8'h1F);
    chk("R4 code3 off", par_en, 0);
    chk("R5 all on", {ser_en, fdc_en}, 3'b111);
    poke(8'hE2, 8'hE2);
    chk("R4 code2 on", par_en, 1);
    chk("R5 all off", {ser_en, fdc_en}, 3'b000);
    poke(8'hE2, 8'h08);
    chk("R5 ser1 only", {par_en, ser_en, fdc_en}, 4'b1100);
    poke(8'hE2, 8'h11);
    chk("R5 fdc only", {par_en, ser_en, fdc_en}, 4'b1001);
  endtask

  task automatic t_bases();
    logic [7:0] v;
    poke(8'hE3, 8'h7B); peek(8'hE3, v);
    chk("R6 fdc mask", v, 8'h78); chk("R6 fdc base", fdc_base, exp_base(8'h78));
    poke(8'hE6, 8'h23); peek(8'hE6, v);
    chk("R7 par raw", v, 8'h23); chk("R7 par base", par_base, exp_base(8'h23));
    poke(8'hE7, 8'hFF); peek(8'hE7, v);
    chk("R8 ser0 mask", v, 8'hFE); chk("R8 ser0 base", ser0_base, 10'h3F8);
    poke(8'hE8, 8'h5F); peek(8'hE8, v);
    chk("R8 ser1 mask", v, 8'h5E); chk("R8 ser1 base", ser1_base, 10'h178);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    poke(8'hE0, 8'h00); peek(8'hE0, v); chk("R9 id kept", v, 8'h3C);
    for (int i = 8'hFD; i <= 8'hFF; i++) begin
      poke(8'(i), 8'hFF); peek(8'(i), v); chk("R9 ro reads zero", v, 8'h00);
    end
    chk("R9 bases kept", {fdc_base, par_base}, {exp_base(8'h78), exp_base(8'h23)});
    chk("R9 fsel kept", {par_en, ser_en, fdc_en}, 4'b1001);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    poke(8'hE1, 8'hAA); peek(8'hE1, v); chk("R10 E1 zero", v, 8'h00);
    poke(8'hE4, 8'h55); peek(8'hE4, v); chk("R10 E4 zero", v, 8'h00);
    peek(8'h10, v); chk("R10 low idx zero", v, 8'h00);
    chk("R10 state kept", {fdc_base, ser0_base, ser1_base, par_base},
        {exp_base(8'h78), 10'h3F8, 10'h178, exp_base(8'h23)});
  endtask

  task automatic t_strobe();
    logic [7:0] v;
    put(0, 8'hE6);
    @(negedge clk); host_port = 1; host_wdata = 8'h99; host_wr = 0;
    @(negedge clk); @(negedge clk);
    peek(8'hE6, v); chk("R12 no strobe", v, 8'h23);
  endtask

  task automatic probe(input logic [9:0] a, input logic [4:0] exp, input string req);
    io_addr = a; #1;
    chk(req, {par_sel, ser_sel, fdc_sel}, exp);
  endtask

  task automatic t_select();
    poke(8'hE2, 8'h1C);
    poke(8'hE6, 8'hDE);
    poke(8'hE3, 8'hFC);
    poke(8'hE8, 8'hBE);
    // order {par, ser1, ser0, fdc}
    probe(10'h378, 4'b1000, "R11 par first");
    probe(10'h37B, 4'b1000, "R11 par last");
    probe(10'h37C, 4'b0000, "R11 par past");
    probe(10'h3F0, 4'b0001, "R11 fdc first");
    probe(10'h3F7, 4'b0001, "R11 fdc last");
    probe(10'h3F8, 4'b0010, "R11 ser0 first");
    probe(10'h3FF, 4'b0010, "R11 ser0 last");
    probe(10'h2F7, 4'b0000, "R11 ser1 before");
    probe(10'h2FF, 4'b0100, "R11 ser1 last");
    poke(8'hE2, 8'h03);
    probe(10'h378, 4'b0000, "R11 par disabled");
    probe(10'h3F8, 4'b0000, "R11 ser0 disabled");
    probe(10'h3F0, 4'b0000, "R11 fdc disabled");
  endtask

  initial begin
    rst = 1; host_port = 0; host_wr = 0; host_wdata = 0; io_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_index();
    t_fsel();
    t_bases();
    t_readonly();
    t_unimpl();
    t_strobe();
    t_select();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule